// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Interrupt Pin

This block watches the running calendar. It compares the current seconds, minutes, hours and day-of-month against four programmable alarm registers. The top bit of each alarm register is a mask bit. The four mask bits together choose how often the alarm repeats: every second, once a minute, once an hour, once a day or once a month.

When the time matches, the block sets an alarm flag. If alarms are enabled, it also pulls down an active-low, open-drain-style interrupt pin. Software releases the pin by accessing the flag register, and the flag itself clears when that access ends. While the system runs from its backup battery, an extra enable must also be set before the pin can fire. A power-up event clears the enables and keeps the flag. When alarms are disabled, the same pin can carry a 512 Hz square wave so the oscillator frequency can be measured.

The comparison is made once per second, in the cycle of the seconds strobe. The time fields are expected to hold the updated time in that cycle, so each match raises exactly one flag-set event. A small register window is reached through a level-held access strobe. Address 0 holds the alarm seconds, 1 the alarm minutes, 2 the alarm hours and 3 the alarm day-of-month. Address 4 is control and address 5 is flags.

Top module: `tod_alarm`

## Requirements
- R1: Mask value 1111 fires on every seconds strobe. The mask value is read as {day-of-month[7], hour[7], minute[7], second[7]} of the alarm registers. Every mask value other than 1111, 0111, 0011, 0001 and 0000 also fires on every seconds strobe.
- R2: Mask 0111 fires only when the current seconds equal the alarm seconds (bits 6:0).
- R3: Mask 0011 fires only when both minutes and seconds match.
- R4: Mask 0001 fires only when hours (bits 5:0), minutes and seconds all match.
- R5: Mask 0000 fires only when day-of-month (bits 5:0), hours, minutes and seconds all match.
- R6: A firing sets the alarm flag, seen on `alarm_flag` and as bit 6 of register 5, whatever the enables are. `irq_oe` goes to 1 and `irq_n` to 0 only if alarm-enable (register 4 bit 7) is set. Both pin changes appear after the clock edge that samples the strobe.
- R7: Any read or write access to register 5 releases the interrupt after the first clock edge of the access. During the access the flag still reads 1. The flag clears at the first clock edge after the access strobe drops.
- R8: While `on_battery` is 1, a firing drives the pin only if both alarm-enable and backup-enable (register 4 bit 6) are set. The flag is still set in either case.
- R9: A `power_up` pulse clears alarm-enable, backup-enable and frequency-test (register 4 bit 0) and leaves the flag unchanged. A firing in the same cycle as the pulse sets the flag without driving the pin.
- R10: The square-wave mode is active when `osc_run`, frequency-test, `wd_steer` or `wd_zero`, and not alarm-enable all hold. In this mode each `ft_tick` toggles the pin, and the first toggle drives it low. Outside the mode the wave stays released.
- R11: After reset the pin is released (`irq_oe`=0, `irq_n`=1), the flag is 0, and registers 0 to 5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle strobe once per second, with the time fields already updated |
| ft_tick | input | 1 | Strobe at 1024 Hz, used for the square-wave mode |
| osc_run | input | 1 | Oscillator running |
| on_battery | input | 1 | System running from backup battery |
| power_up | input | 1 | One-cycle power-up transition event |
| wd_steer | input | 1 | Watchdog output steered to the reset pin |
| wd_zero | input | 1 | Watchdog setting is all zeros |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, BCD, 24-hour format |
| now_date | input | 6 | Current day of month, BCD |
| bus_en | input | 1 | Register access in progress (held for the whole access) |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the register at `bus_addr` |
| irq_n | output | 1 | Interrupt pin level, 0 while pulled low |
| irq_oe | output | 1 | Pull-down enable of the open-drain pin |
| alarm_flag | output | 1 | Alarm flag |

## Verification
Five properties are checked on every cycle:
- the pending interrupt never exists without the flag;
- a flag access with no strobe in the same cycle always releases the pin;
- the flag cannot fall while its register is being accessed;
- a rising interrupt always had the enables that battery mode requires;
- power-up always leaves the three control bits at zero.

Only the directed scenarios can show which masks match which time fields. The same holds for the fallback of illegal masks, the exact cycle in which the flag clears after an access, and the toggling of the square wave against its tick.

// File: rtl/tod_alarm.sv
module tod_alarm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       ft_tick,
  input  logic       osc_run,
  input  logic       on_battery,
  input  logic       power_up,
  input  logic       wd_steer,
  input  logic       wd_zero,
  input  logic [6:0] now_sec,
  input  logic [6:0] now_min,
  input  logic [5:0] now_hour,
  input  logic [5:0] now_date,
  input  logic       bus_en,
  input  logic       bus_we,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_n,
  output logic       irq_oe,
  output logic       alarm_flag
);
  localparam logic [2:0] A_CTRL = 3'd4;
  localparam logic [2:0] A_FLAG = 3'd5;

  logic [7:0] al_sec, al_min, al_hour, al_date;
  logic       ae, abe, ft, af, irq_q, acc_d, sq;
  logic       hit;

  wire        wr       = bus_en && bus_we;
  wire        flag_acc = bus_en && (bus_addr == A_FLAG);
  wire [3:0]  mask     = {al_date[7], al_hour[7], al_min[7], al_sec[7]};
  wire        hit_s    = al_sec[6:0]  == now_sec;
  wire        hit_m    = al_min[6:0]  == now_min;
  wire        hit_h    = al_hour[5:0] == now_hour;
  wire        hit_d    = al_date[5:0] == now_date;
  wire        fire     = sec_tick && hit;
  wire        irq_ok   = ae && (!on_battery || abe) && !power_up;
  wire        ft_mode  = osc_run && ft && !ae && (wd_steer || wd_zero);
  wire        pull     = irq_q || (ft_mode && !sq);

  always_comb begin
    case (mask)
      4'b0111: hit = hit_s;
      4'b0011: hit = hit_s && hit_m;
      4'b0001: hit = hit_s && hit_m && hit_h;
      4'b0000: hit = hit_s && hit_m && hit_h && hit_d;
      default: hit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_sec <= '0; al_min <= '0; al_hour <= '0; al_date <= '0;
    end else if (wr) begin
      case (bus_addr)
        3'd0: al_sec  <= bus_wdata;
        3'd1: al_min  <= bus_wdata;
        3'd2: al_hour <= bus_wdata;
        3'd3: al_date <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae <= 1'b0; abe <= 1'b0; ft <= 1'b0;
    end else if (power_up) begin
      ae <= 1'b0; abe <= 1'b0; ft <= 1'b0;
    end else if (wr && bus_addr == A_CTRL) begin
      ae <= bus_wdata[7]; abe <= bus_wdata[6]; ft <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      af <= 1'b0; irq_q <= 1'b0; acc_d <= 1'b0; sq <= 1'b1;
    end else begin
      acc_d <= flag_acc;
      if (fire)                   af <= 1'b1;
      else if (acc_d && !flag_acc) af <= 1'b0;
      if (fire && irq_ok)         irq_q <= 1'b1;
      else if (flag_acc || acc_d) irq_q <= 1'b0;
      if (!ft_mode)               sq <= 1'b1;
      else if (ft_tick)           sq <= !sq;
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = al_sec;
      3'd1:    bus_rdata = al_min;
      3'd2:    bus_rdata = al_hour;
      3'd3:    bus_rdata = al_date;
      A_CTRL:  bus_rdata = {ae, abe, 5'b0, ft};
      A_FLAG:  bus_rdata = {1'b0, af, 6'b0};
      default: bus_rdata = 8'h00;
    endcase
  end

  assign irq_oe     = pull;
  assign irq_n      = !pull;
  assign alarm_flag = af;

  a_r6_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> af);
  a_r7_access_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_acc && !sec_tick) |=> !irq_q);
  a_r7_flag_held_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_acc && af) |=> af);
  a_r8_battery_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> ($past(ae) && ($past(abe) || !$past(on_battery))));
  a_r9_powerup_clears: assert property (@(posedge clk) disable iff (!rst_n)
    power_up |=> (!ae && !abe && !ft));
endmodule

// File: tb/test_tod_alarm.sv
module test_tod_alarm;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic sec_tick = 0, ft_tick = 0, osc_run = 0, on_battery = 0, power_up = 0;
  logic wd_steer = 0, wd_zero = 0;
  logic [6:0] now_sec = 0, now_min = 0;
  logic [5:0] now_hour = 0, now_date = 0;
  logic bus_en = 0, bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic irq_n, irq_oe, alarm_flag;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  tod_alarm i_tod_alarm (.*);

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic peek(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic set_alarm(logic [3:0] m, logic [5:0] d, logic [5:0] h, logic [6:0] mi, logic [6:0] s);
    wr(3'd0, {m[0], s});
    wr(3'd1, {m[1], mi});
    wr(3'd2, {m[2], 1'b0, h});
    wr(3'd3, {m[3], 1'b0, d});
  endtask

  task automatic tick(logic [5:0] d, logic [5:0] h, logic [6:0] mi, logic [6:0] s);
    @(negedge clk); now_date = d; now_hour = h; now_min = mi; now_sec = s; sec_tick = 1;
    @(negedge clk); sec_tick = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = 3'd5;
    @(negedge clk); @(negedge clk); bus_en = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R11 irq_oe", irq_oe, 0);
    check("R11 irq_n", irq_n, 1);
    check("R11 flag", alarm_flag, 0);
    for (int a = 0; a < 6; a++) begin
      peek(a[2:0], d);
      check("R11 reg", d, 0);
    end
  endtask

  task automatic t_flag_and_enable();
    set_alarm(4'b0111, 0, 0, 0, 7'h30);
    tick(1, 2, 7'h10, 7'h30);
    check("R6 flag without AE", alarm_flag, 1);
    check("R6 no irq without AE", irq_oe, 0);
    clear_flag();
    wr(3'd4, 8'h80);
    tick(1, 2, 7'h10, 7'h30);
    check("R6 irq_oe with AE", irq_oe, 1);
    check("R6 irq_n with AE", irq_n, 0);
  endtask

  task automatic t_release();
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = 3'd5;
    #1 check("R7 before edge", irq_oe, 1);
    @(negedge clk);
    check("R7 released", irq_oe, 0);
    check("R7 flag reads 1 in access", bus_rdata, 8'h40);
    @(negedge clk);
    check("R7 flag still set", alarm_flag, 1);
    bus_en = 0;
    @(negedge clk);
    check("R7 flag cleared after access", alarm_flag, 0);
  endtask

  task automatic t_masks();
    wr(3'd4, 8'h00);
    set_alarm(4'b0111, 5, 7, 7'h15, 7'h30);
    tick(5, 7, 7'h15, 7'h31);
    check("R2 sec mismatch", alarm_flag, 0);
    tick(9, 3, 7'h44, 7'h30);
    check("R2 sec match", alarm_flag, 1);
    clear_flag();
    set_alarm(4'b0011, 5, 7, 7'h15, 7'h30);
    tick(5, 7, 7'h16, 7'h30);
    check("R3 min mismatch", alarm_flag, 0);
    tick(9, 3, 7'h15, 7'h30);
    check("R3 min+sec match", alarm_flag, 1);
    clear_flag();
    set_alarm(4'b0001, 5, 7, 7'h15, 7'h30);
    tick(5, 8, 7'h15, 7'h30);
    check("R4 hour mismatch", alarm_flag, 0);
    tick(9, 7, 7'h15, 7'h30);
    check("R4 h/m/s match", alarm_flag, 1);
    clear_flag();
    set_alarm(4'b0000, 5, 7, 7'h15, 7'h30);
    tick(6, 7, 7'h15, 7'h30);
    check("R5 date mismatch", alarm_flag, 0);
    tick(5, 7, 7'h15, 7'h30);
    check("R5 full match", alarm_flag, 1);
    clear_flag();
    set_alarm(4'b1111, 5, 7, 7'h15, 7'h30);
    tick(1, 1, 7'h01, 7'h02);
    check("R1 every second", alarm_flag, 1);
    clear_flag();
    set_alarm(4'b1010, 5, 7, 7'h15, 7'h30);
    tick(1, 1, 7'h01, 7'h02);
    check("R1 illegal mask fallback", alarm_flag, 1);
    clear_flag();
  endtask

  task automatic t_battery();
    set_alarm(4'b0111, 0, 0, 0, 7'h20);
    wr(3'd4, 8'h80);
    on_battery = 1;
    tick(0, 0, 0, 7'h20);
    check("R8 flag on battery", alarm_flag, 1);
    check("R8 no irq without backup enable", irq_oe, 0);
    clear_flag();
    wr(3'd4, 8'hC0);
    tick(0, 0, 0, 7'h20);
    check("R8 irq with both enables", irq_oe, 1);
    clear_flag();
    on_battery = 0;
  endtask

  task automatic t_powerup();
    logic [7:0] d;
    wr(3'd4, 8'hC1);
    @(negedge clk); now_sec = 7'h20; sec_tick = 1; power_up = 1;
    @(negedge clk); sec_tick = 0; power_up = 0;
    check("R9 flag set during power-up", alarm_flag, 1);
    check("R9 no irq during power-up", irq_oe, 0);
    peek(3'd4, d);
    check("R9 enables cleared", d, 8'h00);
    @(negedge clk); power_up = 1;
    @(negedge clk); power_up = 0;
    check("R9 flag preserved", alarm_flag, 1);
    clear_flag();
  endtask

  task automatic t_freq();
    osc_run = 1; wd_steer = 1;
    wr(3'd4, 8'h01);
    check("R10 idle high", irq_oe, 0);
    @(negedge clk); ft_tick = 1; @(negedge clk); ft_tick = 0;
    check("R10 first toggle low", irq_oe, 1);
    @(negedge clk); ft_tick = 1; @(negedge clk); ft_tick = 0;
    check("R10 second toggle high", irq_oe, 0);
    wd_steer = 0; wd_zero = 0;
    @(negedge clk); ft_tick = 1; @(negedge clk); ft_tick = 0;
    check("R10 steer off no wave", irq_oe, 0);
    wd_zero = 1;
    @(negedge clk); ft_tick = 1; @(negedge clk); ft_tick = 0;
    check("R10 zero watchdog wave", irq_oe, 1);
    osc_run = 0;
    #1 check("R10 oscillator stopped", irq_oe, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_flag_and_enable();
    t_release();
    t_masks();
    t_battery();
    t_powerup();
    t_freq();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule